// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block sits beside the status logic of a 16550-style serial port. It takes the condition signals from the line status flags, the receive path, the transmit holding stage and the modem inputs. It latches those that are event-like, masks them with the four enable bits, and picks the most urgent one by fixed priority. The result is a registered identification byte for the host to read, plus a single active-high interrupt request.

The bus decode supplies one-cycle strobes: reading the identification byte, reading line status, reading modem status, reading the receive buffer, and writing the transmit holding register. Each source has its own clearing strobe. The host learns why it was interrupted by reading the identification byte and then services the reported source. The identification byte is registered, so the value the host reads is the value that decides whether the read acknowledges a transmit-empty interrupt.

Top module: `uart_irq_ident`

## Requirements
- R1: While and after reset, until a source is reported, the identification byte reads 0x01 and the interrupt output is low.
- R2: Bit 0 of the identification byte is 0 when an enabled source is pending and 1 otherwise. When bit 0 is 1, bits 3:1 read 0. The interrupt output is the registered inverse of bit 0.
- R3: Bits 7:6 both equal the FIFO-enable input and bits 5:4 always read 0.
- R4: The source code in bits 2:1 is 11 for line status (highest priority), 10 for receive data or timeout, 01 for transmit empty, and 00 for modem status (lowest). A source whose enable bit is 0 is never reported. The enable bits are: bit 0 receive, bit 1 transmit empty, bit 2 line status, bit 3 modem.
- R5: A line-status source becomes pending when any bit of `lsr_err` goes from 0 to 1. A `rd_lsr` strobe clears it, even if the error flags stay high.
- R6: The receive-data source follows the `rx_avail` level with no latching and is reported as 0x04 (0xC4 in FIFO mode).
- R7: A 0-to-1 change of `rx_timeout` latches a timeout source, which is reported only in FIFO mode, as 0xCC. A `rd_rbr` strobe clears it. When `rx_avail` is also high, 0xC4 is reported instead.
- R8: A 0-to-1 change of `thr_empty` latches a transmit-empty source, and a `wr_thr` strobe clears it.
- R9: An `rd_iir` strobe clears the transmit-empty source only when the identification byte on the port in that cycle shows code 01 with bit 0 low. A higher source shown at that time leaves the transmit-empty source pending.
- R10: Any change of `fifo_en` while `thr_empty` is high makes the transmit-empty source pending again.
- R11: A 0-to-1 change of any `msr_delta` bit latches a modem source, and a `rd_msr` strobe clears it.
- R12: When a source's set event and its clearing strobe fall in the same cycle, the source stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ier_en | input | 4 | Source enables (0 receive, 1 transmit empty, 2 line status, 3 modem) |
| fifo_en | input | 1 | FIFO mode is on |
| lsr_err | input | 4 | Overrun, parity, framing and break flags |
| rx_avail | input | 1 | Receive data ready, or trigger level reached in FIFO mode |
| rx_timeout | input | 1 | Character timeout condition |
| thr_empty | input | 1 | Transmit holding stage empty |
| msr_delta | input | 4 | Modem input change flags |
| rd_iir | input | 1 | Identification byte read strobe |
| rd_lsr | input | 1 | Line status read strobe |
| rd_msr | input | 1 | Modem status read strobe |
| rd_rbr | input | 1 | Receive buffer read strobe |
| wr_thr | input | 1 | Transmit holding write strobe |
| iir | output | 8 | Registered identification byte |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
Two functions can meet in one cycle: the identification-byte read that acknowledges a transmit-empty source, and the arrival of a new source. The bench strobes `rd_iir` while 0x02 is shown and raises `rx_avail` in that same cycle. It expects 0x04, and then 0x01 once the receive level drops, because the transmit-empty source was correctly consumed. It also strobes `rd_iir` while line status is shown and expects the transmit-empty source to survive. Finally, it raises `thr_empty` in the same cycle as a `wr_thr` strobe and expects the source to remain pending.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [1:0] {
        SRC_MODEM  = 2'b00,
        SRC_THRE   = 2'b01,
        SRC_RXDATA = 2'b10,
        SRC_LINE   = 2'b11
    } irq_src_e;

    typedef struct packed {
        logic     active;
        irq_src_e src;
        logic     tmo;
    } irq_sel_t;

    localparam int IER_RX    = 0;
    localparam int IER_THRE  = 1;
    localparam int IER_LINE  = 2;
    localparam int IER_MODEM = 3;
    localparam int IER_W     = 4;

    localparam logic [7:0] IIR_IDLE = 8'h01;

    function automatic logic [7:0] pack_iir(irq_sel_t s, logic fifo);
        return {fifo, fifo, 2'b00, s.tmo, s.src, ~s.active};
    endfunction

endpackage

// File: rtl/irq_src_track.sv
module irq_src_track #(
    parameter int ERR_W   = 4,
    parameter int DELTA_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fifo_en,
    input  logic [ERR_W-1:0]   lsr_err,
    input  logic               rx_timeout,
    input  logic               thr_empty,
    input  logic [DELTA_W-1:0] msr_delta,
    input  logic               rd_lsr,
    input  logic               rd_msr,
    input  logic               rd_rbr,
    input  logic               wr_thr,
    input  logic               thre_ack,
    output logic               line_pend,
    output logic               tmo_pend,
    output logic               thre_pend,
    output logic               modem_pend
);

    logic [ERR_W-1:0]   err_q;
    logic [DELTA_W-1:0] delta_q;
    logic               tmo_q;
    logic               te_q;
    logic               fifo_q;

    logic line_set, tmo_set, thre_set, modem_set;

    always_comb begin
        line_set  = |(lsr_err & ~err_q);
        modem_set = |(msr_delta & ~delta_q);
        tmo_set   = rx_timeout & ~tmo_q;
        thre_set  = thr_empty & (~te_q | (fifo_en ^ fifo_q));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q      <= '0;
            delta_q    <= '0;
            tmo_q      <= 1'b0;
            te_q       <= 1'b0;
            fifo_q     <= 1'b0;
            line_pend  <= 1'b0;
            tmo_pend   <= 1'b0;
            thre_pend  <= 1'b0;
            modem_pend <= 1'b0;
        end else begin
            err_q      <= lsr_err;
            delta_q    <= msr_delta;
            tmo_q      <= rx_timeout;
            te_q       <= thr_empty;
            fifo_q     <= fifo_en;
            // a set event in the clearing cycle wins, so nothing is lost
            line_pend  <= line_set  | (line_pend  & ~rd_lsr);
            modem_pend <= modem_set | (modem_pend & ~rd_msr);
            tmo_pend   <= tmo_set   | (tmo_pend   & ~rd_rbr);
            thre_pend  <= thre_set  | (thre_pend  & ~(wr_thr | thre_ack));
        end
    end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import uart_irq_pkg::*;
(
    input  logic [IER_W-1:0] ier_en,
    input  logic             fifo_en,
    input  logic             rx_avail,
    input  logic             line_pend,
    input  logic             tmo_pend,
    input  logic             thre_pend,
    input  logic             modem_pend,
    output irq_sel_t         sel
);

    logic req_line, req_rx, req_tmo, req_thre, req_modem;

    always_comb begin
        req_line  = line_pend  & ier_en[IER_LINE];
        req_rx    = rx_avail   & ier_en[IER_RX];
        req_tmo   = tmo_pend   & fifo_en & ier_en[IER_RX];
        req_thre  = thre_pend  & ier_en[IER_THRE];
        req_modem = modem_pend & ier_en[IER_MODEM];

        sel = '{active: 1'b0, src: SRC_MODEM, tmo: 1'b0};
        if (req_line) begin
            sel = '{active: 1'b1, src: SRC_LINE, tmo: 1'b0};
        end else if (req_rx) begin
            sel = '{active: 1'b1, src: SRC_RXDATA, tmo: 1'b0};
        end else if (req_tmo) begin
            sel = '{active: 1'b1, src: SRC_RXDATA, tmo: 1'b1};
        end else if (req_thre) begin
            sel = '{active: 1'b1, src: SRC_THRE, tmo: 1'b0};
        end else if (req_modem) begin
            sel = '{active: 1'b1, src: SRC_MODEM, tmo: 1'b0};
        end
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int ERR_W   = 4,
    parameter int DELTA_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [3:0]         ier_en,
    input  logic               fifo_en,
    input  logic [ERR_W-1:0]   lsr_err,
    input  logic               rx_avail,
    input  logic               rx_timeout,
    input  logic               thr_empty,
    input  logic [DELTA_W-1:0] msr_delta,
    input  logic               rd_iir,
    input  logic               rd_lsr,
    input  logic               rd_msr,
    input  logic               rd_rbr,
    input  logic               wr_thr,
    output logic [7:0]         iir,
    output logic               irq
);

    logic     line_pend, tmo_pend, thre_pend, modem_pend;
    logic     thre_ack;
    irq_sel_t sel;
    logic [7:0] iir_q;
    logic       irq_q;

    // the value on the port is the one the host is reading this cycle
    assign thre_ack = rd_iir & ~iir_q[0] & (iir_q[2:1] == SRC_THRE);

    irq_src_track #(.ERR_W(ERR_W), .DELTA_W(DELTA_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .fifo_en    (fifo_en),
        .lsr_err    (lsr_err),
        .rx_timeout (rx_timeout),
        .thr_empty  (thr_empty),
        .msr_delta  (msr_delta),
        .rd_lsr     (rd_lsr),
        .rd_msr     (rd_msr),
        .rd_rbr     (rd_rbr),
        .wr_thr     (wr_thr),
        .thre_ack   (thre_ack),
        .line_pend  (line_pend),
        .tmo_pend   (tmo_pend),
        .thre_pend  (thre_pend),
        .modem_pend (modem_pend)
    );

    irq_prio_enc u_prio (
        .ier_en     (ier_en),
        .fifo_en    (fifo_en),
        .rx_avail   (rx_avail),
        .line_pend  (line_pend),
        .tmo_pend   (tmo_pend),
        .thre_pend  (thre_pend),
        .modem_pend (modem_pend),
        .sel        (sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            iir_q <= IIR_IDLE;
            irq_q <= 1'b0;
        end else begin
            iir_q <= pack_iir(sel, fifo_en);
            irq_q <= sel.active;
        end
    end

    assign iir = iir_q;
    assign irq = irq_q;

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] ier_en,
    input logic       fifo_en,
    input logic [7:0] iir,
    input logic       irq
);

    // R1: leaving reset shows the idle byte with the request low
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (iir == 8'h01 && !irq));

    // R2: an idle byte carries no source code and no request
    assert_idle_form_R2: assert property (@(posedge clk) disable iff (rst)
        iir[0] |-> (iir[3:1] == 3'b000 && !irq));

    // R3: FIFO flag bits track the mode, middle bits stay zero
    assert_fifo_bits_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (iir[7:6] == {2{$past(fifo_en)}} && iir[5:4] == 2'b00));

    // R4: with every source masked no request appears
    assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(ier_en) == 4'h0) |-> !irq);

    // R7: the timeout flag only appears with the receive code and a request
    assert_tmo_form_R7: assert property (@(posedge clk) disable iff (rst)
        iir[3] |-> (iir[2:1] == 2'b10 && !iir[0] && irq));

endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .ier_en  (ier_en),
    .fifo_en (fifo_en),
    .iir     (iir),
    .irq     (irq)
);

// File: tb/tb_uart_irq_ident.sv
`timescale 1ns/100ps
module tb_uart_irq_ident;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] ier_en = '0;
    logic       fifo_en = 1'b0;
    logic [3:0] lsr_err = '0;
    logic       rx_avail = 1'b0;
    logic       rx_timeout = 1'b0;
    logic       thr_empty = 1'b0;
    logic [3:0] msr_delta = '0;
    logic       rd_iir = 1'b0, rd_lsr = 1'b0, rd_msr = 1'b0, rd_rbr = 1'b0, wr_thr = 1'b0;
    logic [7:0] iir;
    logic       irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    uart_irq_ident dut (
        .clk(clk), .rst(rst), .ier_en(ier_en), .fifo_en(fifo_en),
        .lsr_err(lsr_err), .rx_avail(rx_avail), .rx_timeout(rx_timeout),
        .thr_empty(thr_empty), .msr_delta(msr_delta), .rd_iir(rd_iir),
        .rd_lsr(rd_lsr), .rd_msr(rd_msr), .rd_rbr(rd_rbr), .wr_thr(wr_thr),
        .iir(iir), .irq(irq)
    );

    // fields: ier[23:20] fifo[19] err[18:15] rxa[14] tmo[13] te[12] md[11:8] exp[7:0]
    localparam int NV = 15;
    localparam logic [23:0] VEC [NV] = '{
        {4'h0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 4'h0, 8'h01},
        {4'hF, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 4'h0, 8'h01},
        {4'h4, 1'b0, 4'h1, 1'b0, 1'b0, 1'b0, 4'h0, 8'h06},
        {4'h0, 1'b0, 4'h2, 1'b0, 1'b0, 1'b0, 4'h0, 8'h01},
        {4'h1, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 4'h0, 8'h04},
        {4'h1, 1'b1, 4'h0, 1'b0, 1'b1, 1'b0, 4'h0, 8'hCC},
        {4'h1, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 4'h0, 8'h01},
        {4'h1, 1'b1, 4'h0, 1'b1, 1'b1, 1'b0, 4'h0, 8'hC4},
        {4'h2, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 4'h0, 8'h02},
        {4'h8, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 4'h1, 8'h00},
        {4'hF, 1'b0, 4'h8, 1'b1, 1'b1, 1'b1, 4'h2, 8'h06},
        {4'hB, 1'b0, 4'h8, 1'b1, 1'b0, 1'b1, 4'h4, 8'h04},
        {4'hA, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 4'h8, 8'h02},
        {4'h8, 1'b1, 4'h0, 1'b0, 1'b0, 1'b1, 4'h1, 8'hC0},
        {4'h7, 1'b1, 4'h0, 1'b0, 1'b0, 1'b0, 4'h4, 8'hC1}
    };

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] exp);
        n_run++;
        if (iir !== exp || irq !== ~exp[0]) begin
            n_fail++;
            $display("FAIL %s: iir=%02h irq=%0b expected iir=%02h irq=%0b",
                     req, iir, irq, exp, ~exp[0]);
        end
    endtask

    task automatic clear_inputs();
        ier_en = '0; fifo_en = 1'b0; lsr_err = '0; rx_avail = 1'b0;
        rx_timeout = 1'b0; thr_empty = 1'b0; msr_delta = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wait_cyc(2);
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        wait_cyc(2);
        check("R1 in reset", 8'h01);

        // vector walk: codes, priority, masking, mode bits
        for (int i = 0; i < NV; i++) begin
            clear_inputs();
            ier_en     = VEC[i][23:20];
            fifo_en    = VEC[i][19];
            lsr_err    = VEC[i][18:15];
            rx_avail   = VEC[i][14];
            rx_timeout = VEC[i][13];
            thr_empty  = VEC[i][12];
            msr_delta  = VEC[i][11:8];
            do_reset();
            wait_cyc(3);
            check($sformatf("R4 vector %0d", i), VEC[i][7:0]);
        end

        // R5: LSR read clears though flags stay high; a new flag re-raises
        clear_inputs(); do_reset();
        ier_en = 4'h4; lsr_err = 4'h1; wait_cyc(3);
        check("R5 raised", 8'h06);
        rd_lsr = 1'b1; wait_cyc(1); rd_lsr = 1'b0; wait_cyc(2);
        check("R5 cleared by LSR read", 8'h01);
        lsr_err = 4'h3; wait_cyc(3);
        check("R5 new flag", 8'h06);

        // R11: MSR read clears modem source
        clear_inputs(); do_reset();
        ier_en = 4'h8; msr_delta = 4'h2; wait_cyc(3);
        check("R11 raised", 8'h00);
        rd_msr = 1'b1; wait_cyc(1); rd_msr = 1'b0; wait_cyc(2);
        check("R11 cleared by MSR read", 8'h01);

        // R7: receive-buffer read clears timeout
        clear_inputs(); do_reset();
        ier_en = 4'h1; fifo_en = 1'b1; rx_timeout = 1'b1; wait_cyc(3);
        check("R7 timeout", 8'hCC);
        rd_rbr = 1'b1; wait_cyc(1); rd_rbr = 1'b0; wait_cyc(2);
        check("R7 cleared by RBR read", 8'hC1);

        // R6: level source drops with its input
        clear_inputs(); do_reset();
        ier_en = 4'h1; rx_avail = 1'b1; wait_cyc(2);
        check("R6 level on", 8'h04);
        rx_avail = 1'b0; wait_cyc(2);
        check("R6 level off", 8'h01);

        // R8: THR write clears transmit-empty
        clear_inputs(); do_reset();
        ier_en = 4'h2; thr_empty = 1'b1; wait_cyc(3);
        check("R8 raised", 8'h02);
        wr_thr = 1'b1; wait_cyc(1); wr_thr = 1'b0; wait_cyc(2);
        check("R8 cleared by THR write", 8'h01);

        // R10: FIFO mode change re-raises transmit-empty
        fifo_en = 1'b1; wait_cyc(3);
        check("R10 mode change", 8'hC2);

        // R9: IIR read clears transmit-empty when shown
        clear_inputs(); do_reset();
        ier_en = 4'h2; thr_empty = 1'b1; wait_cyc(3);
        rd_iir = 1'b1; wait_cyc(1); rd_iir = 1'b0; wait_cyc(2);
        check("R9 ack while shown", 8'h01);

        // R9: IIR read while line status shown leaves transmit-empty
        clear_inputs(); do_reset();
        ier_en = 4'h6; thr_empty = 1'b1; lsr_err = 4'h4; wait_cyc(3);
        check("R9 line shown", 8'h06);
        rd_iir = 1'b1; wait_cyc(1); rd_iir = 1'b0; wait_cyc(2);
        check("R9 line still shown", 8'h06);
        rd_lsr = 1'b1; wait_cyc(1); rd_lsr = 1'b0; wait_cyc(2);
        check("R9 transmit-empty kept", 8'h02);

        // R9: IIR ack and new receive source in the same cycle
        clear_inputs(); do_reset();
        ier_en = 4'h3; thr_empty = 1'b1; wait_cyc(3);
        rd_iir = 1'b1; rx_avail = 1'b1; wait_cyc(1); rd_iir = 1'b0; wait_cyc(2);
        check("R9 new source during read", 8'h04);
        rx_avail = 1'b0; wait_cyc(2);
        check("R9 consumed source gone", 8'h01);

        // R12: set event in the clearing cycle wins
        clear_inputs(); do_reset();
        ier_en = 4'h2; thr_empty = 1'b1; wait_cyc(3);
        thr_empty = 1'b0; wr_thr = 1'b1; wait_cyc(1); wr_thr = 1'b0; wait_cyc(2);
        check("R12 precondition", 8'h01);
        thr_empty = 1'b1; wr_thr = 1'b1; wait_cyc(1); wr_thr = 1'b0; wait_cyc(2);
        check("R12 set beats clear", 8'h02);

        // R2 and R3: mode bits with idle byte after reset again
        clear_inputs(); fifo_en = 1'b1; do_reset(); wait_cyc(2);
        check("R2 R3 idle in FIFO mode", 8'hC1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule